// File: doc/BRIEF.md
# Three-Counter Event Monitor

This block measures activity inside a processor core. Two general-purpose 32-bit counters each count whichever core event their 8-bit select code picks from a vector of one-cycle event pulses. A third 32-bit counter counts clock cycles only, either every cycle or once per 64 cycles. A single 32-bit control word holds everything that steers the counters and everything that reports their state. That includes one run bit for all three counters, the clear strobes, the prescale choice, the interrupt enables, the sticky wrap flags and both select codes.

Software reaches the control word and the three counters through a small word-addressed register port. Writes take effect at the next clock edge and reads are combinational. No counter has its own run bit. To park one programmable counter while the others keep running, software gives it the idle code 0x20, which selects a trace output that is tied low. Wrap flags clear when a 1 is written to them. An interrupt service routine can therefore write back the exact word it read: doing so clears the flags and leaves every other setting unchanged.

Top module: `evtmon_unit`

## Requirements
- R1: Control bit 0 starts and stops all three counters together; while it is 0 no counter changes except through a register write.
- R2: Writing 1 to control bit 1 zeroes both programmable counters and writing 1 to bit 2 zeroes the cycle counter (and its prescaler); both bits always read back as 0.
- R3: Each counter can be written directly at its own address; when a counter write and an increment fall on the same edge, the counter takes the written value.
- R4: Programmable counter 0 takes its select code from control bits 27:20 and counter 1 from bits 19:12; a code below the event-vector width counts edges at which that event bit is 1, and code 0xFF counts every cycle.
- R5: Code 0x20, and any other code that is neither 0xFF nor a valid event index, never increments the counter.
- R6: Every counter wraps from 0xFFFFFFFF to 0, and the wrap sets its flag: bit 8 for counter 0, bit 9 for counter 1, bit 10 for the cycle counter.
- R7: Writing 1 to a wrap flag clears it, writing 0 leaves it set, and writing back a previously read control word changes nothing but clearing the flags it showed set.
- R8: The interrupt output is high while any wrap flag is set together with its enable (bit 4 counter 0, bit 5 counter 1, bit 6 cycle counter), and it stays high until that flag is cleared.
- R9: With control bit 3 set, the cycle counter advances once per 64 enabled cycles: the first step falls on the 64th enabled edge after the prescaler is cleared.
- R10: Address 0 selects the control word, 1 the cycle counter, 2 counter 0 and 3 counter 1; control bits 31:28, 11, 7 and 2:1 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| evt_in | input | NUM_EVT (32) | Event pulses from the core, one bit per event |
| irq | output | 1 | Level interrupt, any enabled wrap flag |

## Verification
The collision that matters here is a direct counter write landing on the same edge as an increment of that counter. The bench sets counter 0 to the every-cycle code with the monitor running. It then writes a base value and stops the monitor on the next edge. The read-back must be exactly the base value plus one, because a lost write or a doubled increment would each give a different number. A second overlap is a wrap flag being set while a control write leaves it at zero. This is judged from the flag bit and the interrupt level read after the write.

// File: rtl/evtmon_pkg.sv
package evtmon_pkg;
   localparam int DATA_W    = 32;
   localparam int ADDR_W    = 2;
   localparam int SEL_W     = 8;
   localparam int NUM_CNT   = 3;   // 0: prog 0, 1: prog 1, 2: cycle
   localparam int CYC_IDX   = 2;

   // control word bit positions (software-visible layout)
   localparam int B_RUN     = 0;
   localparam int B_CLRP    = 1;
   localparam int B_CLRC    = 2;
   localparam int B_DIV     = 3;
   localparam int B_IE0     = 4;   // enables occupy B_IE0 + counter index
   localparam int B_OVF0    = 8;   // flags occupy B_OVF0 + counter index
   localparam int B_SEL1    = 12;
   localparam int B_SEL0    = 20;

   localparam logic [SEL_W-1:0] CODE_CYCLES = 8'hFF;
   localparam logic [SEL_W-1:0] CODE_IDLE   = 8'h20;

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL = 2'd0,
      A_CYC  = 2'd1,
      A_CNT0 = 2'd2,
      A_CNT1 = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/evtmon_counter.sv
module evtmon_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         inc,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};

   generate
      if (W < 2) begin : g_bad_w
         $error("evtmon_counter: W must be at least 2");
      end
   endgenerate

   assign wrap = inc && !load && !clr && (cnt == MAXV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (load)   cnt <= load_val;
      else if (clr)    cnt <= '0;
      else if (inc)    cnt <= cnt + 1'b1;
   end

   p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));

   p_load_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/evtmon_evsel.sv
module evtmon_evsel
   import evtmon_pkg::*;
#(
   parameter int NUM_EVT = 32
) (
   input  logic [SEL_W-1:0]   sel,
   input  logic [NUM_EVT-1:0] evt_in,
   output logic               hit
);
   generate
      if (NUM_EVT < 1 || NUM_EVT > 255) begin : g_bad_n
         $error("evtmon_evsel: NUM_EVT must be 1..255");
      end
   endgenerate

   always_comb begin
      hit = 1'b0;
      if (sel == CODE_CYCLES) begin
         hit = 1'b1;
      end else if (sel != CODE_IDLE) begin
         for (int k = 0; k < NUM_EVT; k++) begin
            if (sel == SEL_W'(k)) hit = evt_in[k];
         end
      end
   end
endmodule

// File: rtl/evtmon_ctrl.sv
module evtmon_ctrl
   import evtmon_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_CNT-1:0] wrap,
   output logic               run,
   output logic               div,
   output logic               clr_prog,
   output logic               clr_cyc,
   output logic [SEL_W-1:0]   sel0,
   output logic [SEL_W-1:0]   sel1,
   output logic [DATA_W-1:0]  rdata,
   output logic               irq
);
   logic [NUM_CNT-1:0] ie_q;
   logic [NUM_CNT-1:0] ovf_q;
   logic [NUM_CNT-1:0] ovf_clr;
   logic               unused_bits;

   assign unused_bits = ^{wdata[31:28], wdata[11], wdata[7]};

   assign clr_prog = wr && wdata[B_CLRP];
   assign clr_cyc  = wr && wdata[B_CLRC];
   assign ovf_clr  = wr ? wdata[B_OVF0 +: NUM_CNT] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= 1'b0;
         div   <= 1'b0;
         ie_q  <= '0;
         sel0  <= '0;
         sel1  <= '0;
         ovf_q <= '0;
      end else begin
         if (wr) begin
            run  <= wdata[B_RUN];
            div  <= wdata[B_DIV];
            ie_q <= wdata[B_IE0 +: NUM_CNT];
            sel0 <= wdata[B_SEL0 +: SEL_W];
            sel1 <= wdata[B_SEL1 +: SEL_W];
         end
         // a wrap on the same edge as a clear keeps the flag set
         ovf_q <= (ovf_q & ~ovf_clr) | wrap;
      end
   end

   always_comb begin
      rdata = '0;
      rdata[B_RUN]              = run;
      rdata[B_DIV]              = div;
      rdata[B_IE0 +: NUM_CNT]   = ie_q;
      rdata[B_OVF0 +: NUM_CNT]  = ovf_q;
      rdata[B_SEL1 +: SEL_W]    = sel1;
      rdata[B_SEL0 +: SEL_W]    = sel0;
   end

   assign irq = |(ovf_q & ie_q);

   generate
      for (genvar i = 0; i < NUM_CNT; i++) begin : g_flag_chk
         p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_q[i] && !(wr && wdata[B_OVF0 + i])) |=> ovf_q[i]);
      end
   endgenerate

   p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !wr) |=> irq);
endmodule

// File: rtl/evtmon_unit.sv
module evtmon_unit
   import evtmon_pkg::*;
#(
   parameter int NUM_EVT = 32,
   parameter int CNT_W   = 32,
   parameter int PRE_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_EVT-1:0] evt_in,
   output logic               irq
);
   localparam int NUM_PROG = NUM_CNT - 1;
   localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

   generate
      if (CNT_W != DATA_W) begin : g_bad_cw
         $error("evtmon_unit: CNT_W must equal the register width");
      end
      if (PRE_W < 1 || PRE_W > 16) begin : g_bad_pw
         $error("evtmon_unit: PRE_W must be 1..16");
      end
   endgenerate

   logic               wr_ctrl;
   logic               run, div, clr_prog, clr_cyc;
   logic [SEL_W-1:0]   sel0, sel1;
   logic [DATA_W-1:0]  ctrl_rdata;
   logic [NUM_CNT-1:0] wrap;
   logic [NUM_CNT-1:0] inc;
   logic [NUM_CNT-1:0] load;
   logic [CNT_W-1:0]   cnt [NUM_CNT];
   logic [SEL_W-1:0]   sel [NUM_PROG];
   logic [PRE_W-1:0]   pre_q;
   logic               cyc_tick;

   assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
   assign load[0] = reg_we && (reg_addr == A_CNT0);
   assign load[1] = reg_we && (reg_addr == A_CNT1);
   assign load[CYC_IDX] = reg_we && (reg_addr == A_CYC);
   assign sel[0] = sel0;
   assign sel[1] = sel1;

   evtmon_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_ctrl),
      .wdata    (reg_wdata),
      .wrap     (wrap),
      .run      (run),
      .div      (div),
      .clr_prog (clr_prog),
      .clr_cyc  (clr_cyc),
      .sel0     (sel0),
      .sel1     (sel1),
      .rdata    (ctrl_rdata),
      .irq      (irq)
   );

   // cycle prescaler: runs only while the monitor runs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (clr_cyc) pre_q <= '0;
      else if (run)     pre_q <= pre_q + 1'b1;
   end

   assign cyc_tick = run && (!div || (pre_q == PRE_LAST));

   generate
      for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
         logic clr_i;
         if (i == CYC_IDX) begin : g_cyc
            assign inc[i] = cyc_tick;
            assign clr_i  = clr_cyc;
         end else begin : g_prog
            logic hit;
            evtmon_evsel #(.NUM_EVT(NUM_EVT)) u_sel (
               .sel    (sel[i]),
               .evt_in (evt_in),
               .hit    (hit)
            );
            assign inc[i] = run && hit;
            assign clr_i  = clr_prog;
         end

         evtmon_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr_i),
            .load     (load[i]),
            .load_val (reg_wdata[CNT_W-1:0]),
            .inc      (inc[i]),
            .cnt      (cnt[i]),
            .wrap     (wrap[i])
         );

         p_hold_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (!run && !reg_we) |=> $stable(cnt[i]));
      end
   endgenerate

   always_comb begin
      unique case (reg_addr)
         A_CTRL:  reg_rdata = ctrl_rdata;
         A_CYC:   reg_rdata = cnt[CYC_IDX];
         A_CNT0:  reg_rdata = cnt[0];
         default: reg_rdata = cnt[1];
      endcase
   end

   p_clear_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && reg_wdata[B_CLRP]) |=> (cnt[0] == '0 && cnt[1] == '0));

   p_idle_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel0 == CODE_IDLE && !reg_we) |=> $stable(cnt[0]));

   p_div_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && div && !reg_we && pre_q != PRE_LAST) |=> $stable(cnt[CYC_IDX]));
endmodule

// File: tb/evtmon_unit_tb_top.sv
module evtmon_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NEVT = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            reg_we = 1'b0;
   logic [1:0]      reg_addr = 2'd0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic [NEVT-1:0] evt_in = '0;
   logic            irq;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;
   bit chk_req = 1'b0;

   logic [31:0] exp_q [$];
   string       tag_q [$];
   bit          kind_q [$];   // 0: read data, 1: irq level

   always #(CLK_PERIOD/2) clk = ~clk;

   evtmon_unit #(.NUM_EVT(NEVT)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .evt_in    (evt_in),
      .irq       (irq)
   );

   // monitor: pops one expected item per requested check
   always @(negedge clk) begin
      if (chk_req && exp_q.size() > 0) begin
         logic [31:0] e;
         logic [31:0] a;
         string t;
         bit k;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         k = kind_q.pop_front();
         a = k ? {31'd0, irq} : reg_rdata;
         n_vec++;
         if (a !== e) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", t, a, e);
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      step(1);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, logic [31:0] e, string t);
      reg_addr = a;
      exp_q.push_back(e); tag_q.push_back(t); kind_q.push_back(1'b0);
      chk_req = 1'b1;
      step(1);
      chk_req = 1'b0;
   endtask

   task automatic irq_is(bit e, string t);
      exp_q.push_back({31'd0, e}); tag_q.push_back(t); kind_q.push_back(1'b1);
      chk_req = 1'b1;
      step(1);
      chk_req = 1'b0;
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // reset state, R10 map
      rd(2'd0, 32'h0, "R10 ctrl after reset");
      rd(2'd1, 32'h0, "R10 cycle after reset");
      rd(2'd2, 32'h0, "R10 cnt0 after reset");
      rd(2'd3, 32'h0, "R10 cnt1 after reset");
      irq_is(1'b0, "R8 irq after reset");

      // R4 select fields, R10 unused bits read zero
      wr(2'd0, 32'h80305880);
      rd(2'd0, 32'h00305000, "R10 unused ctrl bits / R4 field layout");

      // R1 + R4: run 12 edges, event 3 for 4 edges, event 5 for 7 edges
      wr(2'd0, 32'h00305001);
      evt_in[3] = 1'b1; step(4); evt_in[3] = 1'b0;
      evt_in[5] = 1'b1; step(7); evt_in[5] = 1'b0;
      wr(2'd0, 32'h00305000);
      rd(2'd2, 32'd4,  "R4 cnt0 counts event 3");
      rd(2'd3, 32'd7,  "R4 cnt1 counts event 5");
      rd(2'd1, 32'd12, "R1 cycle counter runs with run bit");

      // R1 stopped: events ignored
      evt_in[3] = 1'b1; step(5); evt_in[3] = 1'b0;
      rd(2'd2, 32'd4, "R1 cnt0 frozen while stopped");

      // R5 idle code and out-of-range code
      wr(2'd0, 32'h02040001);
      evt_in = '1; step(6); evt_in = '0;
      wr(2'd0, 32'h02040000);
      rd(2'd2, 32'd4,  "R5 idle code 0x20 holds cnt0");
      rd(2'd3, 32'd7,  "R5 unmapped code holds cnt1");
      rd(2'd1, 32'd19, "R1 cycle counter 7 more");

      // R2 clear strobes
      wr(2'd0, 32'h00000002);
      rd(2'd2, 32'd0,  "R2 cnt0 cleared");
      rd(2'd3, 32'd0,  "R2 cnt1 cleared");
      rd(2'd1, 32'd19, "R2 cycle untouched by prog clear");
      rd(2'd0, 32'd0,  "R2 clear bit reads zero");
      wr(2'd0, 32'h00000004);
      rd(2'd1, 32'd0,  "R2 cycle cleared");

      // R3 direct write, and write beats increment
      wr(2'd2, 32'h12345678);
      rd(2'd2, 32'h12345678, "R3 direct write cnt0");
      wr(2'd0, 32'h0FF00001);
      wr(2'd2, 32'hABCD0000);
      wr(2'd0, 32'h0FF00000);
      rd(2'd2, 32'hABCD0001, "R3 write wins over increment; R4 code 0xFF");

      // R6 wrap of cnt1, R8 irq
      wr(2'd3, 32'hFFFFFFFE);
      wr(2'd0, 32'h020FF021);
      step(1);
      wr(2'd0, 32'h020FF020);
      rd(2'd3, 32'd0,        "R6 cnt1 wrapped to zero");
      rd(2'd0, 32'h020FF220, "R6 flag bit 9 set");
      irq_is(1'b1, "R8 irq with enabled flag");

      // R7 write 0 keeps, write-back clears
      wr(2'd0, 32'h020FF020);
      rd(2'd0, 32'h020FF220, "R7 writing 0 keeps flag");
      irq_is(1'b1, "R8 irq stays until cleared");
      wr(2'd0, 32'h020FF220);
      rd(2'd0, 32'h020FF020, "R7 write-back clears flag only");
      irq_is(1'b0, "R8 irq drops after clear");

      // R6 cycle wrap with enable off, then enable
      wr(2'd1, 32'hFFFFFFFF);
      wr(2'd0, 32'h02020001);
      wr(2'd0, 32'h02020000);
      rd(2'd1, 32'd0,        "R6 cycle counter wrapped");
      rd(2'd0, 32'h02020400, "R6 flag bit 10 set");
      irq_is(1'b0, "R8 no irq with enable off");
      wr(2'd0, 32'h02020040);
      irq_is(1'b1, "R8 irq once bit 6 set");
      wr(2'd0, 32'h02020440);
      irq_is(1'b0, "R8 irq after cycle flag clear");
      rd(2'd0, 32'h02020040, "R7 enable kept after clear");

      // R9 prescale: 63 edges give nothing, 64th gives one
      wr(2'd0, 32'h00000004);
      wr(2'd0, 32'h02020009);
      step(62);
      wr(2'd0, 32'h02020008);
      rd(2'd1, 32'd0, "R9 no step before 64th edge");
      wr(2'd0, 32'h02020009);
      wr(2'd0, 32'h02020008);
      rd(2'd1, 32'd1, "R9 step on 64th edge");

      step(2);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule